// File: doc/BRIEF.md
# Indexed Port NVRAM Access Bridge

This block lets a host reach a byte-wide non-volatile RAM through a window of four byte-wide I/O ports. The host first writes the address into the register through two index ports, one for the low byte and one for the high byte. It then reads or writes the data port. Each data write also clears the address register, so the next transfer starts from address zero unless the host loads a new address.

Two fixed 16-byte regions of the RAM can be hidden by lock bits. A sideband request flips one of these bits each time it arrives. A hidden region drops writes and reads back as all ones. Addresses at or above the configured RAM size behave the same way.

A read takes one cycle. `port_rdata` takes its new value at the clock edge that samples `port_rd` and keeps it until the next read. Reads never change the address register.

Top module: `nvram_port_bridge`

## Requirements
- R1: A synchronous active-low reset clears the address register and both lock bits and sets `port_rdata` to 0xFF. Reset leaves the RAM contents as they were, so a data read right after reset returns the byte at address 0.
- R2: A write to port offset 0 loads the low address byte. The high address byte keeps its value.
- R3: A write to port offset 1 loads the high address byte. The low address byte keeps its value.
- R4: A write to port offset 3 stores the byte at the current address. On the following cycle the address register is zero.
- R5: A read of port offset 3 returns the byte at the current address one cycle later. The address register is not changed, so repeated reads return the same byte.
- R6: A read of port offset 0, 1 or 2 returns 0xFF. A write to offset 2 changes neither the address register nor the RAM.
- R7: While lock bit 0 is set, data writes to addresses 0x0020 to 0x002F are dropped and data reads there return 0xFF. Lock bit 0 has no effect on other addresses.
- R8: While lock bit 1 is set, data writes to addresses 0x0030 to 0x003F are dropped and data reads there return 0xFF. Lock bit 1 has no effect on other addresses.
- R9: Each cycle with `lock_toggle` high inverts the lock bit chosen by `lock_sel` (0 selects bit 0, 1 selects bit 1). Clearing a lock makes the earlier region contents visible again.
- R10: Data writes at addresses at or above `MEM_BYTES` do not alias into the RAM, and data reads there return 0xFF. The address register still clears after such a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_off | input | 2 | Port offset within the four-byte window |
| port_wr | input | 1 | One-cycle write strobe for the selected port |
| port_wdata | input | 8 | Write data byte |
| port_rd | input | 1 | One-cycle read strobe for the selected port |
| port_rdata | output | 8 | Read data, updated at the edge that samples `port_rd` |
| lock_toggle | input | 1 | Request to invert one lock bit |
| lock_sel | input | 1 | Lock bit chosen by `lock_toggle` |

## Verification
The address register is built up in several orders: high byte then low byte, low byte overwritten on its own, and high byte cleared with the low byte kept. Reading back a distinct value for each order shows whether a byte load corrupts the other byte. Data reads follow writes both with and without a reload of the address, which separates the clear-after-write rule from the read-leaves-address rule. Probes just inside and just outside each lock window, with each lock set alone, show which window each bit guards. Paired addresses below and above the RAM size show whether an out-of-range write wraps onto a low address.

// File: rtl/nvb_pkg.sv
// Package: shared constants and types for the indexed port NVRAM bridge.
// Assumes a 16-bit address space and exactly two 16-byte lock windows.
package nvb_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int NUM_LOCKS = 2;

    // Port offsets inside the four-byte window
    typedef enum logic [1:0] {
        OFF_ADDR_LO = 2'd0,
        OFF_ADDR_HI = 2'd1,
        OFF_SPARE   = 2'd2,
        OFF_DATA    = 2'd3
    } port_off_e;

    // Base address of the window each lock bit hides (16 bytes each)
    localparam logic [ADDR_W-1:0] LOCK_BASE [NUM_LOCKS] = '{16'h0020, 16'h0030};

    // True when addr falls inside the 16-byte window starting at base
    function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] base);
        return addr[ADDR_W-1:4] == base[ADDR_W-1:4];
    endfunction

endpackage

// File: rtl/nvb_index_reg.sv
// Module: nvb_index_reg
// Holds the 16-bit address register. Offsets 0 and 1 load the low and high
// byte. A data-port write clears the register. Reads leave it alone.
// Assumes one write strobe per cycle at most.
module nvb_index_reg
    import nvb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic [ADDR_W-1:0] addr
);

    // Address register update on index and data writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (wr) begin
            case (off)
                OFF_ADDR_LO: addr[7:0]  <= wdata;
                OFF_ADDR_HI: addr[15:8] <= wdata;
                OFF_DATA:    addr       <= '0;
                default:     addr       <= addr;
            endcase
        end
    end

    p_low_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == OFF_ADDR_LO) |=> (addr[7:0] == $past(wdata) && addr[15:8] == $past(addr[15:8])));

    p_high_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == OFF_ADDR_HI) |=> (addr[15:8] == $past(wdata) && addr[7:0] == $past(addr[7:0])));

    p_clear_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == OFF_DATA) |=> (addr == '0));

    p_read_keeps_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> $stable(addr));

    p_spare_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == OFF_SPARE) |=> $stable(addr));

endmodule

// File: rtl/nvb_lock_ctrl.sv
// Module: nvb_lock_ctrl
// Keeps the lock bits. Each toggle request inverts the selected bit. The
// module reports whether the current address lies in a locked window.
// Assumes the window bases in nvb_pkg do not overlap.
module nvb_lock_ctrl
    import nvb_pkg::*;
#(
    parameter int N_LOCKS = NUM_LOCKS,
    localparam int SEL_W  = (N_LOCKS > 1) ? $clog2(N_LOCKS) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              toggle,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_LOCKS-1:0] lock_q,
    output logic              blocked
);

    logic [N_LOCKS-1:0] hit;

    for (genvar i = 0; i < N_LOCKS; i++) begin : g_lock
        // Flip this lock bit when it is the selected one
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[i] <= 1'b0;
            else if (toggle && sel == SEL_W'(i))
                lock_q[i] <= ~lock_q[i];
        end

        // Window hit for this lock
        assign hit[i] = in_window(addr, LOCK_BASE[i]);

        p_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (toggle && sel == SEL_W'(i)) |=> (lock_q[i] != $past(lock_q[i])));
    end

    // Blocked when any locked window covers the address
    always_comb blocked = |(lock_q & hit);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle |=> $stable(lock_q));

endmodule

// File: rtl/nvb_store.sv
// Module: nvb_store
// Byte-wide RAM with a synchronous write port and a registered read port.
// Assumes the caller gates both enables with a range check. Contents are
// not reset.
module nvb_store
    import nvb_pkg::*;
#(
    parameter int DEPTH  = 2048,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write and read the array; the read returns the old contents
    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
        if (re)
            rdata <= mem[idx];
    end

endmodule

// File: rtl/nvram_port_bridge.sv
// Module: nvram_port_bridge (top)
// Four-byte indexed port window onto a byte-wide RAM of MEM_BYTES bytes.
// Combines the address register, the lock gating and the RAM, and forces
// all ones on reads of index ports, locked windows and out-of-range
// addresses. Assumes MEM_BYTES is at most 65536.
module nvram_port_bridge
    import nvb_pkg::*;
#(
    parameter int MEM_BYTES = 2048
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] port_off,
    input  logic       port_wr,
    input  logic [7:0] port_wdata,
    input  logic       port_rd,
    output logic [7:0] port_rdata,
    input  logic       lock_toggle,
    input  logic       lock_sel
);

    localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
    localparam logic [ADDR_W:0] SIZE_L = (ADDR_W+1)'(MEM_BYTES);

    logic [ADDR_W-1:0]    addr;
    logic [NUM_LOCKS-1:0] lock_q;
    logic                 blocked;
    logic                 in_range;
    logic                 data_sel;
    logic                 allowed;
    logic [DATA_W-1:0]    mem_q;
    logic                 ones_q;

    nvb_index_reg u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (port_wr),
        .off   (port_off),
        .wdata (port_wdata),
        .rd    (port_rd),
        .addr  (addr)
    );

    nvb_lock_ctrl #(.N_LOCKS(NUM_LOCKS)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .toggle  (lock_toggle),
        .sel     (lock_sel),
        .addr    (addr),
        .lock_q  (lock_q),
        .blocked (blocked)
    );

    // Access qualification for the data port
    always_comb begin
        in_range = {1'b0, addr} < SIZE_L;
        data_sel = (port_off == OFF_DATA);
        allowed  = in_range && !blocked;
    end

    nvb_store #(.DEPTH(MEM_BYTES)) u_store (
        .clk   (clk),
        .we    (port_wr && data_sel && allowed),
        .re    (port_rd && data_sel && allowed),
        .idx   (addr[IDX_W-1:0]),
        .wdata (port_wdata),
        .rdata (mem_q)
    );

    // Remember whether the latest read must return all ones
    always_ff @(posedge clk) begin
        if (!rst_n)
            ones_q <= 1'b1;
        else if (port_rd)
            ones_q <= !(data_sel && allowed);
    end

    // Read data mux
    always_comb port_rdata = ones_q ? 8'hFF : mem_q;

    p_index_read_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && port_off != OFF_DATA) |=> (port_rdata == 8'hFF));

    p_lock0_read_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && port_off == OFF_DATA && lock_q[0] && addr[15:4] == 12'h002) |=> (port_rdata == 8'hFF));

    p_lock1_read_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && port_off == OFF_DATA && lock_q[1] && addr[15:4] == 12'h003) |=> (port_rdata == 8'hFF));

    p_range_read_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && port_off == OFF_DATA && {1'b0, addr} >= SIZE_L) |=> (port_rdata == 8'hFF));

    p_rdata_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_rd && !port_wr) |=> $stable(port_rdata));

endmodule

// File: tb/nvram_port_bridge_tb.sv
module nvram_port_bridge_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_off = 2'd0;
    logic       port_wr = 1'b0;
    logic [7:0] port_wdata = 8'h00;
    logic       port_rd = 1'b0;
    logic [7:0] port_rdata;
    logic       lock_toggle = 1'b0;
    logic       lock_sel = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    logic rd_d = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    nvram_port_bridge #(.MEM_BYTES(2048)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_off    (port_off),
        .port_wr     (port_wr),
        .port_wdata  (port_wdata),
        .port_rd     (port_rd),
        .port_rdata  (port_rdata),
        .lock_toggle (lock_toggle),
        .lock_sel    (lock_sel)
    );

    // Remember which cycles carried a read strobe
    always @(posedge clk) rd_d <= port_rd;

    // Monitor: compare each read result against the scoreboard queue
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (port_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: got %02h expected %02h", t, port_rdata, e);
            end
        end
    end

    task automatic wr(input logic [1:0] off, input logic [7:0] d);
        @(negedge clk);
        port_off = off; port_wdata = d; port_wr = 1'b1;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] off, input logic [7:0] e, input string t);
        @(negedge clk);
        port_off = off; port_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        port_rd = 1'b0;
    endtask

    task automatic set_addr(input logic [15:0] a);
        wr(2'd1, a[15:8]);
        wr(2'd0, a[7:0]);
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        set_addr(a);
        wr(2'd3, d);
    endtask

    task automatic peek(input logic [15:0] a, input logic [7:0] e, input string t);
        set_addr(a);
        rd(2'd3, e, t);
    endtask

    task automatic flip(input logic s);
        @(negedge clk);
        lock_sel = s; lock_toggle = 1'b1;
        @(negedge clk);
        lock_toggle = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: read data is all ones out of reset
        n_tests++;
        if (port_rdata !== 8'hFF) begin
            n_fail++;
            $display("FAIL R1 rdata after reset: got %02h expected ff", port_rdata);
        end
        wr(2'd3, 8'h5A);            // address is zero after reset
        poke(16'h0025, 8'h11);      // lock window 0 contents before reset
        flip(1'b0);                 // lock 0 set, reset must clear it
        do_reset();
        rd(2'd3, 8'h5A, "R1 address zero and RAM kept");
        peek(16'h0025, 8'h11, "R1 lock cleared by reset");

        // R2 / R3 / R4 / R5
        poke(16'h0123, 8'hA1);
        poke(16'h0023, 8'h3C);
        rd(2'd3, 8'h5A, "R4 address cleared after data write");
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h40);
        wr(2'd0, 8'h23);
        rd(2'd3, 8'hA1, "R2 low load keeps high byte");
        wr(2'd1, 8'h00);
        rd(2'd3, 8'h3C, "R3 high load keeps low byte");
        rd(2'd3, 8'h3C, "R5 repeated read same byte");

        // R6
        rd(2'd0, 8'hFF, "R6 read offset 0");
        rd(2'd1, 8'hFF, "R6 read offset 1");
        rd(2'd2, 8'hFF, "R6 read offset 2");
        set_addr(16'h0123);
        wr(2'd2, 8'h99);
        rd(2'd3, 8'hA1, "R6 offset 2 write ignored");

        // R7 / R9
        poke(16'h0035, 8'h22);
        poke(16'h001F, 8'h33);
        poke(16'h0040, 8'h44);
        poke(16'h0030, 8'h55);
        flip(1'b0);
        poke(16'h0025, 8'hEE);
        peek(16'h0025, 8'hFF, "R7 locked window reads ones");
        peek(16'h001F, 8'h33, "R7 below window readable");
        peek(16'h0035, 8'h22, "R7 lock 0 leaves window 1");
        flip(1'b0);
        peek(16'h0025, 8'h11, "R9 second toggle unlocks, write dropped");

        // R8 / R9
        flip(1'b1);
        peek(16'h0035, 8'hFF, "R8 locked window reads ones");
        peek(16'h0040, 8'h44, "R8 above window readable");
        peek(16'h0025, 8'h11, "R8 lock 1 leaves window 0");
        poke(16'h0030, 8'hEE);
        flip(1'b1);
        peek(16'h0030, 8'h55, "R9 unlock shows old data, write dropped");

        // R10
        poke(16'h0010, 8'h66);
        poke(16'h0810, 8'hBB);
        rd(2'd3, 8'h5A, "R10 address cleared after out-of-range write");
        peek(16'h0010, 8'h66, "R10 no alias on write");
        peek(16'h0810, 8'hFF, "R10 out-of-range read");
        peek(16'hFFFF, 8'hFF, "R10 top address read");
        poke(16'h07FF, 8'h7E);
        peek(16'h07FF, 8'h7E, "R10 last in-range byte");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule